// File: doc/BRIEF.md
# Set-Associative Address Translation Cache with Access Checks

This block caches virtual-to-physical page translations for 32-bit virtual addresses and 4 KiB pages. It holds 32 entries arranged as 8 sets of 4 ways. A lookup request carries a virtual address and two access-type bits: user or supervisor, and read or write. One cycle later the block returns a result code and, on a permitted hit, the physical address.

Each cached entry holds a page frame number and three flags: present, writable and user-accessible. On a tag hit these flags are checked. A non-present page gives a page fault. A user access that the flags forbid gives a protection fault. A separate fill port installs a tag, a frame and the flags into a chosen set. The way that receives them is picked by a round-robin pointer kept for each set. A flush input invalidates every entry.

Surrounding logic reacts to a miss or a fault. It walks the page tables, decides which faults are fatal, and sends new translations back through the fill port.

Top module: `tlb_top`

## Requirements
- R1: The virtual address is decoded as follows. Bits 31:15 are the tag, bits 14:12 select one of 8 sets, and bits 11:0 are the page offset. An entry installed in one set is never matched by a lookup whose index selects another set.
- R2: A lookup hits only when a way of the indexed set is valid and its stored tag equals the address tag. In every other case, including a tag match on an invalidated entry, the result code is 01 (miss) and rsp_paddr is 0.
- R3: An entry's flags field is defined as follows. Bit 0 is present, bit 1 is writable and bit 2 is user-accessible. The frame field supplies physical address bits 31:12.
- R4: A hit on an entry whose present flag is 0 returns code 10 (page fault). This applies to any access type, and it takes priority over any protection fault.
- R5: A hit on a present entry returns code 11 (protection fault) in two cases: a user access to an entry whose user flag is 0, or a user write to an entry whose writable flag is 0. Supervisor accesses are not checked against the user or writable flags.
- R6: A permitted hit returns code 00 with rsp_paddr equal to the entry's frame followed by the request's 12-bit offset. Any other code returns rsp_paddr = 0.
- R7: Each set has a 2-bit way pointer that is 0 after reset. A fill writes the entry into the pointed way, marks it valid and advances that set's pointer only, wrapping from 3 to 0. The fifth fill into a set therefore replaces the first.
- R8: A flush invalidates all 32 entries at the next clock edge. A fill presented in the same cycle as a flush is discarded.
- R9: rsp_valid is high exactly one cycle after each cycle in which req_valid is high, and low otherwise. The result reflects the table contents before any fill or flush in the same cycle as the request.
- R10: If several valid ways in a set hold the same tag, the lowest-numbered way supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_user | input | 1 | 1 for a user access, 0 for supervisor |
| req_write | input | 1 | 1 for a write, 0 for a read |
| fill_valid | input | 1 | Install an entry this cycle |
| fill_tag | input | 17 | Tag of the entry being installed |
| fill_set | input | 3 | Set that receives the entry |
| fill_frame | input | 20 | Physical frame number of the entry |
| fill_flags | input | 3 | Flags: bit 0 present, bit 1 writable, bit 2 user |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Result strobe, one cycle after a request |
| rsp_kind | output | 2 | 00 hit, 01 miss, 10 page fault, 11 protection fault |
| rsp_paddr | output | 32 | Physical address on a hit, else 0 |

## Verification
The assertions hold on every cycle for the following: the one-cycle pairing of requests and result strobes, the zero address on non-hit results, and the offset carried into a hit address. They also check that the registered code agrees with the lookup's internal miss, page-fault and protection-fault signals, and that nothing hits in the cycle after a flush. Several behaviours depend on the history of fills across many cycles, so only the bench scenarios can show them: round-robin replacement evicting the oldest way, set isolation, duplicate-tag priority, the discarded fill during a flush, and the ordering of a request against a fill or flush in the same cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Result codes returned on rsp_kind
  typedef enum logic [1:0] {
    RES_HIT  = 2'b00,
    RES_MISS = 2'b01,
    RES_PAGE = 2'b10,
    RES_PROT = 2'b11
  } tlb_res_e;

  // Positions inside the 3-bit flags field
  localparam int unsigned FLG_PRESENT  = 0;
  localparam int unsigned FLG_WRITABLE = 1;
  localparam int unsigned FLG_USER     = 2;
  localparam int unsigned FLG_W        = 3;

  // A user access is denied if the page is not user-accessible,
  // or if it is a write to a read-only page.
  function automatic logic perm_denied(input logic writable, input logic user_ok,
                                       input logic is_user, input logic is_write);
    return is_user && (!user_ok || (is_write && !writable));
  endfunction

  // Page fault outranks protection fault.
  function automatic tlb_res_e classify(input logic hit, input logic present,
                                        input logic denied);
    if (!hit)     return RES_MISS;
    if (!present) return RES_PAGE;
    if (denied)   return RES_PROT;
    return RES_HIT;
  endfunction

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned WAYS    = 4,
  parameter int unsigned TAG_W   = 17,
  parameter int unsigned ENTRY_W = 23,
  localparam int unsigned SETS   = 1 << IDX_W,
  localparam int unsigned WAY_W  = $clog2(WAYS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [ENTRY_W-1:0]       wr_entry,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [WAYS-1:0]          rd_valid,
  output logic [WAYS*TAG_W-1:0]    rd_tags,
  output logic [WAYS*ENTRY_W-1:0]  rd_entries
);

  logic [SETS*WAYS-1:0]         valid_flat;
  logic [SETS*WAYS*TAG_W-1:0]   tag_flat;
  logic [SETS*WAYS*ENTRY_W-1:0] entry_flat;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:0]  v_q;
    logic [WAY_W-1:0] p_q;
    logic             set_sel;

    assign set_sel = wr_en && (wr_idx == IDX_W'(s));

    // Valid bits and replacement pointer: the only reset state.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= '0;
        p_q <= '0;
      end else if (flush) begin
        v_q <= '0;
      end else if (set_sel) begin
        v_q[p_q] <= 1'b1;
        p_q      <= (p_q == WAY_W'(WAYS - 1)) ? '0 : p_q + WAY_W'(1);
      end
    end

    assign valid_flat[s*WAYS +: WAYS] = v_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0]   tag_q;
      logic [ENTRY_W-1:0] ent_q;

      // Payload is qualified by the valid bit, so it carries no reset.
      always_ff @(posedge clk) begin
        if (set_sel && (p_q == WAY_W'(w))) begin
          tag_q <= wr_tag;
          ent_q <= wr_entry;
        end
      end

      assign tag_flat[(s*WAYS + w)*TAG_W +: TAG_W]       = tag_q;
      assign entry_flat[(s*WAYS + w)*ENTRY_W +: ENTRY_W] = ent_q;
    end
  end

  // Read port: all ways of the indexed set.
  assign rd_valid   = valid_flat[rd_idx*WAYS +: WAYS];
  assign rd_tags    = tag_flat[rd_idx*WAYS*TAG_W +: WAYS*TAG_W];
  assign rd_entries = entry_flat[rd_idx*WAYS*ENTRY_W +: WAYS*ENTRY_W];

endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
  parameter int unsigned WAYS    = 4,
  parameter int unsigned TAG_W   = 17,
  parameter int unsigned ENTRY_W = 23
) (
  input  logic [TAG_W-1:0]         look_tag,
  input  logic [WAYS-1:0]          valid,
  input  logic [WAYS*TAG_W-1:0]    tags,
  input  logic [WAYS*ENTRY_W-1:0]  entries,
  output logic                     hit_any,
  output logic [ENTRY_W-1:0]       sel_entry
);

  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid[w] && (tags[w*TAG_W +: TAG_W] == look_tag);
  end

  assign hit_any = |hit_vec;

  // Walk from the top way down so that the lowest matching way is kept.
  always_comb begin
    sel_entry = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) sel_entry = entries[w*ENTRY_W +: ENTRY_W];
    end
  end

endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned FRAME_W  = VA_W - PAGE_BITS,
  localparam int unsigned ENTRY_W  = FRAME_W + FLG_W
) (
  input  logic                 hit_any,
  input  logic [ENTRY_W-1:0]   entry,
  input  logic [PAGE_BITS-1:0] offset,
  input  logic                 is_user,
  input  logic                 is_write,
  output tlb_res_e             kind,
  output logic [VA_W-1:0]      paddr,
  output logic                 page_fault,
  output logic                 prot_fault
);

  logic [FRAME_W-1:0] frame;
  logic               f_present;
  logic               f_writable;
  logic               f_user;
  logic               denied;

  assign frame      = entry[ENTRY_W-1:FLG_W];
  assign f_present  = entry[FLG_PRESENT];
  assign f_writable = entry[FLG_WRITABLE];
  assign f_user     = entry[FLG_USER];

  assign denied     = perm_denied(f_writable, f_user, is_user, is_write);
  assign page_fault = hit_any && !f_present;
  assign prot_fault = hit_any && f_present && denied;

  assign kind  = classify(hit_any, f_present, denied);
  assign paddr = (kind == RES_HIT) ? {frame, offset} : '0;

endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned SETS      = 8,
  parameter int unsigned WAYS      = 4,
  localparam int unsigned IDX_W    = $clog2(SETS),
  localparam int unsigned TAG_W    = VA_W - PAGE_BITS - IDX_W,
  localparam int unsigned FRAME_W  = VA_W - PAGE_BITS,
  localparam int unsigned ENTRY_W  = FRAME_W + FLG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_user,
  input  logic               req_write,
  input  logic               fill_valid,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic [IDX_W-1:0]   fill_set,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic [FLG_W-1:0]   fill_flags,
  input  logic               flush,
  output logic               rsp_valid,
  output logic [1:0]         rsp_kind,
  output logic [VA_W-1:0]    rsp_paddr
);

  // Address field extraction
  function automatic logic [TAG_W-1:0] va_tag(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] va_idx(input logic [VA_W-1:0] va);
    return va[PAGE_BITS +: IDX_W];
  endfunction

  function automatic logic [PAGE_BITS-1:0] va_off(input logic [VA_W-1:0] va);
    return va[PAGE_BITS-1:0];
  endfunction

  // Named internal events
  logic [TAG_W-1:0]        lkp_tag;
  logic [IDX_W-1:0]        lkp_idx;
  logic [PAGE_BITS-1:0]    lkp_off;
  logic                    fill_en;
  logic [WAYS-1:0]         lkp_valid;
  logic [WAYS*TAG_W-1:0]   lkp_tags;
  logic [WAYS*ENTRY_W-1:0] lkp_entries;
  logic                    lkp_hit_any;
  logic [ENTRY_W-1:0]      lkp_entry;
  tlb_res_e                lkp_kind;
  logic [VA_W-1:0]         lkp_paddr;
  logic                    lkp_page_fault;
  logic                    lkp_prot_fault;

  assign lkp_tag = va_tag(req_vaddr);
  assign lkp_idx = va_idx(req_vaddr);
  assign lkp_off = va_off(req_vaddr);

  // Flush wins over a fill in the same cycle.
  assign fill_en = fill_valid && !flush;

  tlb_entry_array #(
    .IDX_W   (IDX_W),
    .WAYS    (WAYS),
    .TAG_W   (TAG_W),
    .ENTRY_W (ENTRY_W)
  ) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .wr_en      (fill_en),
    .wr_idx     (fill_set),
    .wr_tag     (fill_tag),
    .wr_entry   ({fill_frame, fill_flags}),
    .rd_idx     (lkp_idx),
    .rd_valid   (lkp_valid),
    .rd_tags    (lkp_tags),
    .rd_entries (lkp_entries)
  );

  tlb_way_match #(
    .WAYS    (WAYS),
    .TAG_W   (TAG_W),
    .ENTRY_W (ENTRY_W)
  ) u_match (
    .look_tag  (lkp_tag),
    .valid     (lkp_valid),
    .tags      (lkp_tags),
    .entries   (lkp_entries),
    .hit_any   (lkp_hit_any),
    .sel_entry (lkp_entry)
  );

  tlb_perm_check #(
    .VA_W      (VA_W),
    .PAGE_BITS (PAGE_BITS)
  ) u_perm (
    .hit_any    (lkp_hit_any),
    .entry      (lkp_entry),
    .offset     (lkp_off),
    .is_user    (req_user),
    .is_write   (req_write),
    .kind       (lkp_kind),
    .paddr      (lkp_paddr),
    .page_fault (lkp_page_fault),
    .prot_fault (lkp_prot_fault)
  );

  // Registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= RES_MISS;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_kind  <= lkp_kind;
        rsp_paddr <= lkp_paddr;
      end
    end
  end

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [PAGE_BITS-1:0] req_off,
  input logic                 flush,
  input logic                 lkp_hit_any,
  input logic                 lkp_page_fault,
  input logic                 lkp_prot_fault,
  input logic                 rsp_valid,
  input logic [1:0]           rsp_kind,
  input logic [VA_W-1:0]      rsp_paddr
);

  assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_miss_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !lkp_hit_any) |=> (rsp_kind == RES_MISS));

  assert_page_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lkp_page_fault) |=> (rsp_kind == RES_PAGE));

  assert_prot_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lkp_prot_fault) |=> (rsp_kind == RES_PROT));

  assert_hit_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lkp_hit_any && !lkp_page_fault && !lkp_prot_fault)
      |=> (rsp_kind == RES_HIT) && (rsp_paddr[PAGE_BITS-1:0] == $past(req_off)));

  assert_zero_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind != RES_HIT) |-> (rsp_paddr == '0));

  assert_flush_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lkp_hit_any);

endmodule

bind tlb_top tlb_checker #(
  .VA_W      (VA_W),
  .PAGE_BITS (PAGE_BITS)
) u_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_off        (req_vaddr[PAGE_BITS-1:0]),
  .flush          (flush),
  .lkp_hit_any    (lkp_hit_any),
  .lkp_page_fault (lkp_page_fault),
  .lkp_prot_fault (lkp_prot_fault),
  .rsp_valid      (rsp_valid),
  .rsp_kind       (rsp_kind),
  .rsp_paddr      (rsp_paddr)
);

// File: tb/tb_tlb_top.sv
module tb_tlb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_user = 1'b0;
  logic        req_write = 1'b0;
  logic        fill_valid = 1'b0;
  logic [16:0] fill_tag = '0;
  logic [2:0]  fill_set = '0;
  logic [19:0] fill_frame = '0;
  logic [2:0]  fill_flags = '0;
  logic        flush = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_kind;
  logic [31:0] rsp_paddr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  tlb_top dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_user(req_user), .req_write(req_write),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_set(fill_set),
    .fill_frame(fill_frame), .fill_flags(fill_flags),
    .flush(flush),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_paddr(rsp_paddr)
  );

  // Reference table kept by the bench
  logic [16:0] m_tag   [8][4];
  logic [31:0] m_word  [8][4];
  bit          m_valid [8][4];
  int          m_ptr   [8];

  // Scoreboard
  logic [33:0] exp_q [$];
  string       req_q [$];

  function automatic logic [31:0] mkva(input logic [16:0] t, input logic [2:0] s,
                                       input logic [11:0] o);
    return {t, s, o};
  endfunction

  // Expected {code, address}: 0 hit, 1 miss, 2 page fault, 3 protection fault
  function automatic logic [33:0] predict(input logic [31:0] va, input bit u, input bit w);
    logic [16:0] t = va[31:15];
    int          s = int'(va[14:12]);
    int          found = -1;
    logic [31:0] word;
    for (int k = 3; k >= 0; k--)
      if (m_valid[s][k] && m_tag[s][k] == t) found = k;
    if (found < 0) return {2'd1, 32'h0};
    word = m_word[s][found];
    if (word[0] == 1'b0) return {2'd2, 32'h0};
    if (u && (word[2] == 1'b0 || (w && word[1] == 1'b0))) return {2'd3, 32'h0};
    return {2'd0, word[31:12], va[11:0]};
  endfunction

  task automatic step(input bit rq, input logic [31:0] va, input bit u, input bit w,
                      input bit fv, input logic [16:0] ft, input logic [2:0] fs,
                      input logic [31:0] fw, input bit fl, input string rtag);
    @(negedge clk);
    if (rq) begin
      exp_q.push_back(predict(va, u, w));
      req_q.push_back(rtag);
    end
    req_valid  = rq;
    req_vaddr  = va;
    req_user   = u;
    req_write  = w;
    fill_valid = fv;
    fill_tag   = ft;
    fill_set   = fs;
    fill_frame = fw[31:12];
    fill_flags = fw[2:0];
    flush      = fl;
    if (fl) begin
      for (int s = 0; s < 8; s++)
        for (int k = 0; k < 4; k++) m_valid[s][k] = 1'b0;
    end else if (fv) begin
      m_valid[fs][m_ptr[fs]] = 1'b1;
      m_tag[fs][m_ptr[fs]]   = ft;
      m_word[fs][m_ptr[fs]]  = fw;
      m_ptr[fs]              = (m_ptr[fs] + 1) % 4;
    end
    @(posedge clk);
    #1;
    req_valid  = 1'b0;
    fill_valid = 1'b0;
    flush      = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input bit u, input bit w, input string rtag);
    step(1'b1, va, u, w, 1'b0, '0, '0, '0, 1'b0, rtag);
  endtask

  task automatic fill(input logic [16:0] t, input logic [2:0] s, input logic [31:0] word);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, t, s, word, 1'b0, "");
  endtask

  // Monitor: compare each result against the oldest expectation
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R9 unexpected response: actual kind=%0d paddr=%h expected=none",
                 rsp_kind, rsp_paddr);
      end else begin
        logic [33:0] e;
        string       r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if ({rsp_kind, rsp_paddr} !== e)
          $display("FAIL %s: actual kind=%0d paddr=%h expected kind=%0d paddr=%h",
                   r, rsp_kind, rsp_paddr, e[33:32], e[31:0]);
        if ({rsp_kind, rsp_paddr} !== e) bad++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 8; s++) begin
      m_ptr[s] = 0;
      for (int k = 0; k < 4; k++) begin
        m_valid[s][k] = 1'b0;
        m_tag[s][k]   = '0;
        m_word[s][k]  = '0;
      end
    end
    repeat (3) @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0 || rsp_paddr !== 32'h0) begin
      bad++;
      $display("FAIL R9 reset state: actual valid=%b paddr=%h expected valid=0 paddr=0",
               rsp_valid, rsp_paddr);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // Empty table
    lookup(mkva(17'h0365c, 3'd4, 12'h47c), 1, 1, "R2 empty table miss");

    // Present, not user-accessible
    fill(17'h09718, 3'd3, 32'h0022f003);
    lookup(mkva(17'h09718, 3'd3, 12'h80c), 1, 1, "R5 user flag clear");
    lookup(mkva(17'h09718, 3'd3, 12'h80c), 0, 1, "R5 supervisor bypasses flags");

    // Fully permitted page
    fill(17'h0911b, 3'd6, 32'h003c0067);
    lookup(mkva(17'h0911b, 3'd6, 12'h99c), 1, 1, "R6 permitted user write");
    lookup(mkva(17'h0911b, 3'd6, 12'h000), 1, 0, "R3 frame field to address");

    // Read-only user page
    fill(17'h0f9d3, 3'd7, 32'h00248025);
    lookup(mkva(17'h0f9d3, 3'd7, 12'he7c), 1, 1, "R5 user write to read-only");
    lookup(mkva(17'h0f9d3, 3'd7, 12'he7c), 1, 0, "R5 user read of read-only");
    lookup(mkva(17'h0f9d3, 3'd7, 12'h004), 0, 1, "R5 supervisor write to read-only");

    // Not present pages
    fill(17'h098c1, 3'd3, 32'h0014a006);
    lookup(mkva(17'h098c1, 3'd3, 12'h80c), 1, 1, "R4 not present");
    fill(17'h1b0b0, 3'd2, 32'h00000002);
    lookup(mkva(17'h1b0b0, 3'd2, 12'h010), 1, 1, "R4 page fault outranks protection");
    lookup(mkva(17'h1b0b0, 3'd2, 12'h010), 0, 0, "R4 supervisor read not present");

    // Set isolation
    lookup(mkva(17'h0911b, 3'd5, 12'h99c), 1, 1, "R1 same tag other set");
    lookup(mkva(17'h09718, 3'd6, 12'h80c), 0, 0, "R1 same tag other set");

    // Flush
    step(1'b0, '0, 0, 0, 1'b0, '0, '0, '0, 1'b1, "");
    lookup(mkva(17'h0911b, 3'd6, 12'h99c), 1, 1, "R8 flushed entry");
    lookup(mkva(17'h09718, 3'd3, 12'h80c), 0, 0, "R2 tag match on invalid entry");

    // Round-robin replacement in set 5; set 2 filled in between
    for (int i = 1; i <= 4; i++)
      fill(17'h10000 + 17'(i), 3'd5, {20'h00100 + 20'(i), 12'h007});
    fill(17'h1abcd, 3'd2, 32'h00777007);
    fill(17'h10005, 3'd5, 32'h00105007);
    lookup(mkva(17'h10001, 3'd5, 12'h111), 1, 1, "R7 oldest way replaced");
    for (int i = 2; i <= 5; i++)
      lookup(mkva(17'h10000 + 17'(i), 3'd5, 12'h222), 1, 1, "R7 remaining ways hit");
    lookup(mkva(17'h1abcd, 3'd2, 12'h333), 1, 1, "R7 other set untouched");

    // Duplicate tag in set 1
    fill(17'h0abcd, 3'd1, 32'h000aa007);
    fill(17'h0abcd, 3'd1, 32'h000bb007);
    lookup(mkva(17'h0abcd, 3'd1, 12'h444), 1, 1, "R10 lowest way wins");

    // Same-cycle ordering
    step(1'b1, mkva(17'h1f00f, 3'd0, 12'h123), 1, 0,
         1'b1, 17'h1f00f, 3'd0, 32'h12345007, 1'b0, "R9 lookup before same-cycle fill");
    lookup(mkva(17'h1f00f, 3'd0, 12'h123), 1, 0, "R9 fill visible next cycle");
    step(1'b1, mkva(17'h1f00f, 3'd0, 12'h456), 1, 1,
         1'b0, '0, '0, '0, 1'b1, "R9 lookup before same-cycle flush");
    step(1'b0, '0, 0, 0, 1'b1, 17'h1eeee, 3'd4, 32'h00999007, 1'b1, "");
    lookup(mkva(17'h1eeee, 3'd4, 12'h555), 1, 1, "R8 fill during flush dropped");
    lookup(mkva(17'h1f00f, 3'd0, 12'h123), 1, 0, "R8 flush cleared entry");

    repeat (3) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R9 missing responses: actual pending=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule